// File: doc/BRIEF.md
# Segment Base-Limit Translation Unit

This unit turns a segmented logical address (segment number plus offset) into a physical address. The segment table lives in external memory. Two inputs give its word address in memory and the number of segments it holds. Software or a surrounding controller keeps both values stable.

For each accepted request the unit first checks that the segment number is within the table length. If it is, the unit fetches the one table entry it needs over a single-request memory port. It then tests, in a fixed priority order, the entry's valid flag, the offset against the segment size, and the access type against the entry's permission bits. When every check passes it adds the segment base to the offset. Each request ends with a one-cycle `done` strobe, carrying either a physical address or a non-zero fault code.

Top module: `segXlateUnit`

## Requirements
- R1: A request whose segment number is greater than or equal to `tableLen` ends with fault code 1 and physical address 0. No memory read is issued, and `done` rises in the cycle after the request is accepted.
- R2: Any other request issues exactly one memory read. `memReq` is high for one cycle, starting in the cycle after acceptance, with `memAddr` = (`tableBase` + segment number) modulo 2^MEM_AW.
- R3: A table entry word holds, from bit 0 upward: the base in bits [PADDR_W-1:0], the size in the next OFF_W+1 bits, then the execute bit, the write bit, the read bit, and the valid bit as the top bit.
- R4: An entry whose valid bit is 0 gives fault code 2.
- R5: An offset greater than or equal to the entry's size gives fault code 3.
- R6: The access type is 0 for read, 1 for write and 2 for execute. It needs the entry's read, write or execute bit respectively, or the result is fault code 4. Access type 3 always gives fault code 4.
- R7: When several checks fail, the reported code is the first one in this order: length (1), valid (2), size (3), permission (4). Fault code 0 means success.
- R8: With no fault, `physAddr` = (base + offset) modulo 2^PADDR_W. With any fault, `physAddr` is 0.
- R9: After a read, `done` is high for exactly one cycle: the cycle after the one in which `memRvalid` is high. `busy` is high from the cycle after acceptance until that read data arrives.
- R10: `reqValid` is ignored while `busy` is high. It starts no read and does not change the result of the request in flight.
- R11: After reset, `done`, `busy`, `memReq`, `fault` and `physAddr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tableBase | input | MEM_AW | Word address of segment table entry 0 |
| tableLen | input | SEG_W+1 | Number of segments in the table |
| reqValid | input | 1 | Request strobe, taken only when idle |
| reqSeg | input | SEG_W | Segment number |
| reqOff | input | OFF_W | Offset within the segment |
| reqAcc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| busy | output | 1 | A table read is outstanding |
| memReq | output | 1 | One-cycle read request for a table entry |
| memAddr | output | MEM_AW | Entry word address |
| memRvalid | input | 1 | Read data valid this cycle |
| memRdata | input | PADDR_W+OFF_W+5 | Table entry word |
| done | output | 1 | One-cycle result strobe |
| fault | output | 3 | Fault code, 0 when translation succeeded |
| physAddr | output | PADDR_W | Translated physical address |

## Verification
The bench builds the unit with SEG_W=3, OFF_W=4, PADDR_W=8 and MEM_AW=6. With these sizes it can sweep every segment number, every offset and every access type. Each sweep runs against table lengths of 0, 5 and full (8), with two table bases. One base makes the entry address wrap past the top of the 64-word memory. The bench generates entries arithmetically so that sizes fall below, equal to and above the offsets in use, and the valid and permission bits cover every combination. This places every fault priority case and every size boundary within reach. Read latency varies from zero to two cycles, and stray requests arrive while a read is outstanding.

// File: rtl/segXlatePkg.sv
package segXlatePkg;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_LEN     = 3'd1,
    FLT_INVALID = 3'd2,
    FLT_LIMIT   = 3'd3,
    FLT_PRIV    = 3'd4
  } faultE;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  typedef struct packed {
    logic capReq;     // request accepted this cycle
    logic capResult;  // table entry arrives this cycle
  } ctrlStrbT;

endpackage

// File: rtl/segXlateCtrl.sv
module segXlateCtrl
  import segXlatePkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     lenOk,
  input  logic     memRvalid,
  output ctrlStrbT strb,
  output logic     memReq,
  output logic     done,
  output logic     busy
);

  typedef enum logic {ST_IDLE, ST_WAIT} stateE;
  stateE state;

  always_comb begin
    strb.capReq    = (state == ST_IDLE) && reqValid;
    strb.capResult = (state == ST_WAIT) && memRvalid;
  end

  assign busy = (state == ST_WAIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      memReq <= 1'b0;
      done   <= 1'b0;
    end else begin
      memReq <= strb.capReq && lenOk;
      done   <= (strb.capReq && !lenOk) || strb.capResult;
      if (strb.capReq && lenOk)
        state <= ST_WAIT;
      else if (strb.capResult)
        state <= ST_IDLE;
    end
  end

  // R2: a read request never lasts more than one cycle
  p_single_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // R1: an out-of-range segment finishes without touching memory
  p_len_no_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && !lenOk) |=> (done && !memReq && !busy));

  // R9: result follows the read data by one cycle
  p_done_after_data_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && memRvalid) |=> (done && !busy));

  // R10: a request seen while busy starts no new read
  p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !memRvalid) |=> (busy && !memReq));

endmodule

// File: rtl/segXlateDp.sv
module segXlateDp
  import segXlatePkg::*;
#(
  parameter int SEG_W   = 4,
  parameter int OFF_W   = 8,
  parameter int PADDR_W = 12,
  parameter int MEM_AW  = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrbT                 strb,
  input  logic [MEM_AW-1:0]        tableBase,
  input  logic [SEG_W:0]           tableLen,
  input  logic [SEG_W-1:0]         reqSeg,
  input  logic [OFF_W-1:0]         reqOff,
  input  logic [1:0]               reqAcc,
  input  logic [PADDR_W+OFF_W+4:0] memRdata,
  output logic                     lenOk,
  output logic [MEM_AW-1:0]        memAddr,
  output logic [2:0]               fault,
  output logic [PADDR_W-1:0]       physAddr
);

  localparam int LIM_W = OFF_W + 1;
  localparam int ENT_W = PADDR_W + LIM_W + 4;
  localparam int LIM_LO = PADDR_W;
  localparam int X_BIT = PADDR_W + LIM_W;

  logic [OFF_W-1:0]   offQ;
  logic [1:0]         accQ;
  faultE              faultQ;
  logic [PADDR_W-1:0] physQ;

  // entry field decode
  logic [PADDR_W-1:0] entBase;
  logic [LIM_W-1:0]   entLim;
  logic               entX, entW, entR, entV;
  logic               privOk;
  logic [LIM_W-1:0]   offExt;

  assign entBase = memRdata[PADDR_W-1:0];
  assign entLim  = memRdata[LIM_LO +: LIM_W];
  assign entX    = memRdata[X_BIT];
  assign entW    = memRdata[X_BIT+1];
  assign entR    = memRdata[X_BIT+2];
  assign entV    = memRdata[ENT_W-1];
  assign offExt  = {1'b0, offQ};

  assign lenOk = ({1'b0, reqSeg} < tableLen);

  always_comb begin
    case (accQ)
      ACC_READ:  privOk = entR;
      ACC_WRITE: privOk = entW;
      ACC_EXEC:  privOk = entX;
      default:   privOk = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
      offQ    <= '0;
      accQ    <= '0;
      faultQ  <= FLT_NONE;
      physQ   <= '0;
    end else begin
      if (strb.capReq) begin
        memAddr <= tableBase + MEM_AW'(reqSeg);
        offQ    <= reqOff;
        accQ    <= reqAcc;
        if (!lenOk) begin
          faultQ <= FLT_LEN;
          physQ  <= '0;
        end
      end
      if (strb.capResult) begin
        physQ <= '0;
        if (!entV)
          faultQ <= FLT_INVALID;
        else if (offExt >= entLim)
          faultQ <= FLT_LIMIT;
        else if (!privOk)
          faultQ <= FLT_PRIV;
        else begin
          faultQ <= FLT_NONE;
          physQ  <= entBase + PADDR_W'(offQ);
        end
      end
    end
  end

  assign fault    = faultQ;
  assign physAddr = physQ;

  // R8: a faulted translation never exposes an address
  p_fault_zero_addr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fault != 3'd0) |-> (physAddr == '0));

  // R1: out-of-range segment yields the length code
  p_len_code_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capReq && !lenOk) |=> (fault == 3'd1));

  // R7: only the defined codes ever appear
  p_code_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    fault <= 3'd4);

  // R4: an invalid entry always ends with the invalid code
  p_invalid_code_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capResult && !entV) |=> (fault == 3'd2));

endmodule

// File: rtl/segXlateUnit.sv
module segXlateUnit
  import segXlatePkg::*;
#(
  parameter int SEG_W   = 4,
  parameter int OFF_W   = 8,
  parameter int PADDR_W = 12,
  parameter int MEM_AW  = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [MEM_AW-1:0]        tableBase,
  input  logic [SEG_W:0]           tableLen,
  input  logic                     reqValid,
  input  logic [SEG_W-1:0]         reqSeg,
  input  logic [OFF_W-1:0]         reqOff,
  input  logic [1:0]               reqAcc,
  output logic                     busy,
  output logic                     memReq,
  output logic [MEM_AW-1:0]        memAddr,
  input  logic                     memRvalid,
  input  logic [PADDR_W+OFF_W+4:0] memRdata,
  output logic                     done,
  output logic [2:0]               fault,
  output logic [PADDR_W-1:0]       physAddr
);

  ctrlStrbT strb;
  logic     lenOk;

  segXlateCtrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .lenOk     (lenOk),
    .memRvalid (memRvalid),
    .strb      (strb),
    .memReq    (memReq),
    .done      (done),
    .busy      (busy)
  );

  segXlateDp #(
    .SEG_W   (SEG_W),
    .OFF_W   (OFF_W),
    .PADDR_W (PADDR_W),
    .MEM_AW  (MEM_AW)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .tableBase (tableBase),
    .tableLen  (tableLen),
    .reqSeg    (reqSeg),
    .reqOff    (reqOff),
    .reqAcc    (reqAcc),
    .memRdata  (memRdata),
    .lenOk     (lenOk),
    .memAddr   (memAddr),
    .fault     (fault),
    .physAddr  (physAddr)
  );

endmodule

// File: tb/test_segXlateUnit.sv
module test_segXlateUnit;

  localparam int SEG_W   = 3;
  localparam int OFF_W   = 4;
  localparam int PADDR_W = 8;
  localparam int MEM_AW  = 6;
  localparam int ENT_W   = PADDR_W + OFF_W + 5;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic [MEM_AW-1:0]    tableBase = '0;
  logic [SEG_W:0]       tableLen = '0;
  logic                 reqValid = 1'b0;
  logic [SEG_W-1:0]     reqSeg = '0;
  logic [OFF_W-1:0]     reqOff = '0;
  logic [1:0]           reqAcc = '0;
  logic                 busy, memReq, done;
  logic [MEM_AW-1:0]    memAddr;
  logic                 memRvalid = 1'b0;
  logic [ENT_W-1:0]     memRdata = '0;
  logic [2:0]           fault;
  logic [PADDR_W-1:0]   physAddr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  segXlateUnit #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .PADDR_W(PADDR_W), .MEM_AW(MEM_AW)
  ) i_segXlateUnit (
    .clk(clk), .rstN(rstN), .tableBase(tableBase), .tableLen(tableLen),
    .reqValid(reqValid), .reqSeg(reqSeg), .reqOff(reqOff), .reqAcc(reqAcc),
    .busy(busy), .memReq(memReq), .memAddr(memAddr), .memRvalid(memRvalid),
    .memRdata(memRdata), .done(done), .fault(fault), .physAddr(physAddr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R3: entry layout {valid, read, write, exec, size[4:0], base[7:0]}
  function automatic logic [ENT_W-1:0] entryAt(input int i);
    logic v, r, w, x;
    logic [4:0] lim;
    logic [7:0] b;
    v   = (i % 5) != 3;
    r   = (i % 2) == 1;
    w   = ((i / 2) % 2) == 1;
    x   = ((i / 4) % 2) == 1;
    lim = 5'((i * 3) % 20);
    b   = 8'((i * 37) % 256);
    return {v, r, w, x, lim, b};
  endfunction

  task automatic runOne(input int tb, input int tl, input int seg, input int off,
                        input int acc, input int lat, input bit intrude);
    int addr, expFault, expPhys;
    logic [ENT_W-1:0] e;
    bit privOk;
    @(negedge clk);
    tableBase = MEM_AW'(tb); tableLen = (SEG_W+1)'(tl);
    reqSeg = SEG_W'(seg); reqOff = OFF_W'(off); reqAcc = 2'(acc);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    addr = (tb + seg) % 64;
    e = entryAt(addr);
    if (seg >= tl) begin
      // R1: length fault, no read, done next cycle
      chk(done == 1'b1 && memReq == 1'b0, "R1 done/no-read", int'({done, memReq}), 2);
      chk(fault == 3'd1 && physAddr == '0, "R1 code", int'(fault), 1);
      @(negedge clk);
      chk(done == 1'b0, "R9 single done", int'(done), 0);
      return;
    end
    // R2: one read to base+segment
    chk(memReq == 1'b1 && busy == 1'b1 && done == 1'b0, "R2 read issued",
        int'({memReq, busy, done}), 6);
    chk(memAddr == MEM_AW'(addr), "R2 address", int'(memAddr), addr);
    if (intrude) begin
      reqValid = 1'b1; reqSeg = SEG_W'(seg ^ 1); reqOff = ~reqOff; reqAcc = 2'(acc ^ 1);
    end
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      reqValid = 1'b0;
      // R10: stray request starts nothing; R2: request is one cycle
      chk(memReq == 1'b0 && done == 1'b0 && busy == 1'b1, "R10 wait idle",
          int'({memReq, done, busy}), 1);
    end
    memRvalid = 1'b1;
    memRdata = e;
    @(negedge clk);
    memRvalid = 1'b0;
    reqValid = 1'b0;
    // R4 R5 R6 R7 R8: expected code by priority
    case (acc)
      0: privOk = e[15];
      1: privOk = e[14];
      2: privOk = e[13];
      default: privOk = 1'b0;
    endcase
    expPhys = 0;
    if (!e[16]) expFault = 2;
    else if (off >= int'(e[12:8])) expFault = 3;
    else if (!privOk) expFault = 4;
    else begin expFault = 0; expPhys = (int'(e[7:0]) + off) % 256; end
    chk(done == 1'b1 && busy == 1'b0, "R9 done after data", int'({done, busy}), 2);
    chk(fault == 3'(expFault), "R7 fault code", int'(fault), expFault);
    chk(physAddr == PADDR_W'(expPhys), "R8 phys addr", int'(physAddr), expPhys);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0 && memReq == 1'b0, "R9 R10 quiet after",
        int'({done, busy, memReq}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(done == 0 && busy == 0 && memReq == 0 && fault == 0 && physAddr == 0,
        "R11 reset", int'({done, busy, memReq, fault}), 0);
    rstN = 1'b1;
    n = 0;
    foreach (tbList[t]) begin
      foreach (tlList[l]) begin
        for (int s = 0; s < 8; s++)
          for (int o = 0; o < 16; o++)
            for (int a = 0; a < 4; a++) begin
              runOne(tbList[t], tlList[l], s, o, a, n % 3, (n % 4) == 1);
              n++;
            end
      end
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  int tbList[2] = '{0, 60};
  int tlList[3] = '{0, 5, 8};

endmodule